// File: doc/BRIEF.md
# Data-Strobe Splitter with Transfer Acknowledge

This glue block lets a host bus with a single active-low data strobe and a read/not-write direction signal talk to a peripheral that expects separate active-low read and write strobes. The host also supplies an active-low chip enable already decoded from its address. When the peripheral is selected, the block routes the data strobe onto the read strobe or the write strobe, depending on the direction signal. The peripheral strobes stay idle whenever the chip enable is inactive, so accesses to other devices never toggle them.

The host cycle ends with an active-low transfer acknowledge. A shift chain clocked by the system clock produces it. The chain fills only while a selected strobe is present, so the acknowledge appears a fixed number of clock edges after the access begins. Each stage clears asynchronously the moment the data strobe is withdrawn, and no acknowledge left over from one cycle can reach the next. An active-high synchronous reset empties the chain. The chain depth is a parameter with a default of two.

Top module: `strobe_splitter`

## Requirements
- R1: With ds_n=0, ce_n=0 and rnw=1, rd_n is 0 and wr_n is 1 in the same cycle, with no clock edge needed.
- R2: With ds_n=0, ce_n=0 and rnw=0, wr_n is 0 and rd_n is 1 in the same cycle, with no clock edge needed.
- R3: When ce_n=1 or ds_n=1, both rd_n and wr_n are 1. rd_n and wr_n are never 0 together.
- R4: ack_n is 0 only while ds_n=0 and ce_n=0 both hold.
- R5: With the default depth of two, after a selected strobe begins, ack_n is still 1 after the first rising clock edge and becomes 0 after the second.
- R6: ack_n stays 0 for as long as ds_n and ce_n remain 0.
- R7: When ds_n returns to 1, ack_n goes to 1 at once, without waiting for a clock edge. The next selected strobe again waits the full two edges.
- R8: If ce_n goes to 1 while ds_n is still 0, rd_n, wr_n and ack_n go to 1 at once. An unselected strobe never produces ack_n=0.
- R9: Clock edges with rst=1 hold ack_n at 1 and empty the chain. After rst is released with a selected strobe present, ack_n becomes 0 after the second following edge.
- R10: A selected strobe that spans only one rising clock edge never produces ack_n=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that drives the acknowledge chain |
| rst | input | 1 | Active-high synchronous reset |
| ds_n | input | 1 | Host data strobe, active low |
| rnw | input | 1 | Host direction: 1 for read, 0 for write |
| ce_n | input | 1 | Decoded chip enable, active low |
| rd_n | output | 1 | Peripheral read strobe, active low |
| wr_n | output | 1 | Peripheral write strobe, active low |
| ack_n | output | 1 | Transfer acknowledge to the host, active low |

## Verification
The clocked properties assume that the host holds the data strobe inactive across at least one rising clock edge between accesses. They also assume that ds_n, ce_n and rnw change only away from the rising edge, as a synchronous host bus does. The stimulus changes every input on the falling clock edge and leaves an idle clock period with the strobe high after each access. Mid-cycle withdrawal of the chip enable and reset during an active strobe are driven on the falling edge as well, so every clocked property sees clean values at the rising edge.

// File: rtl/strobe_splitter_pkg.sv
package strobe_splitter_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } access_e;

    localparam int unsigned DEFAULT_ACK_DEPTH = 2;

endpackage

// File: rtl/access_decode.sv
module access_decode
    import strobe_splitter_pkg::*;
(
    input  logic    ds_n,
    input  logic    rnw,
    input  logic    ce_n,
    output access_e kind,
    output logic    sel
);

    always_comb begin
        sel  = !ds_n && !ce_n;
        kind = ACC_IDLE;
        if (sel) begin
            kind = rnw ? ACC_READ : ACC_WRITE;
        end
    end

endmodule

// File: rtl/ack_pipe.sv
module ack_pipe #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ds_n,
    input  logic sel,
    output logic full
);

    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = sel && !rst;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.stage[i] = st_q.stage[i-1] && sel && !rst;
        end
    end

    always_ff @(posedge clk or posedge ds_n) begin
        if (ds_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.stage[LAST];

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_order
            // R5
            stage_order_chk: assert property (@(posedge clk) disable iff (rst || ds_n)
                $rose(st_q.stage[g]) |-> $past(st_q.stage[g-1]))
                else $error("stage %0d filled out of order", g);
        end
    endgenerate

    // R9
    reset_empties_chk: assert property (@(posedge clk)
        rst |=> (st_q.stage == '0))
        else $error("chain not empty after reset edge");

endmodule

// File: rtl/strobe_splitter.sv
module strobe_splitter
    import strobe_splitter_pkg::*;
#(
    parameter int unsigned ACK_DEPTH = DEFAULT_ACK_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic ds_n,
    input  logic rnw,
    input  logic ce_n,
    output logic rd_n,
    output logic wr_n,
    output logic ack_n
);

    access_e kind;
    logic    sel;
    logic    full;

    access_decode u_decode (
        .ds_n (ds_n),
        .rnw  (rnw),
        .ce_n (ce_n),
        .kind (kind),
        .sel  (sel)
    );

    ack_pipe #(.DEPTH(ACK_DEPTH)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .ds_n (ds_n),
        .sel  (sel),
        .full (full)
    );

    assign rd_n  = (kind != ACC_READ);
    assign wr_n  = (kind != ACC_WRITE);
    assign ack_n = !(full && sel);

    // R3
    always_comb begin
        one_strobe_chk: assert (!(!rd_n && !wr_n)) else $error("read and write strobes both active");
    end

    // R4
    always_comb begin
        ack_selected_chk: assert (ack_n || (!ds_n && !ce_n)) else $error("acknowledge without selection");
    end

    // R10
    ack_needs_history_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> $past(!ds_n && !ce_n))
        else $error("acknowledge without prior selected edge");

    // R6
    ack_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !ds_n && !ce_n) |=> (ds_n || ce_n || rst || !ack_n))
        else $error("acknowledge dropped while still selected");

    // R9
    reset_ack_chk: assert property (@(posedge clk)
        rst |=> (ack_n || !$past(rst)))
        else $error("acknowledge active after reset edge");

endmodule

// File: tb/strobe_splitter_test.sv
`timescale 1ns/1ps
module strobe_splitter_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ds_n = 1'b1;
    logic rnw = 1'b1;
    logic ce_n = 1'b1;
    logic rd_n, wr_n, ack_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    strobe_splitter uut (
        .clk   (clk),
        .rst   (rst),
        .ds_n  (ds_n),
        .rnw   (rnw),
        .ce_n  (ce_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .ack_n (ack_n)
    );

    // fields: ce_n, rnw, hold edges, exp rd_n, exp wr_n, exp ack
    typedef struct packed {
        logic       ce;
        logic       dir;
        logic [3:0] hold;
        logic       erd;
        logic       ewr;
        logic       eack;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ce:1'b0, dir:1'b1, hold:4'd2, erd:1'b0, ewr:1'b1, eack:1'b1},
        '{ce:1'b0, dir:1'b0, hold:4'd2, erd:1'b1, ewr:1'b0, eack:1'b1},
        '{ce:1'b1, dir:1'b1, hold:4'd3, erd:1'b1, ewr:1'b1, eack:1'b0},
        '{ce:1'b1, dir:1'b0, hold:4'd3, erd:1'b1, ewr:1'b1, eack:1'b0},
        '{ce:1'b0, dir:1'b1, hold:4'd6, erd:1'b0, ewr:1'b1, eack:1'b1},
        '{ce:1'b0, dir:1'b0, hold:4'd1, erd:1'b1, ewr:1'b0, eack:1'b1}
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(rd_n, 1'b1, "R3 reset rd_n");
        check(wr_n, 1'b1, "R3 reset wr_n");
        check(ack_n, 1'b1, "R9 reset ack_n");
        @(negedge clk);
        rst = 1'b0;
        step();

        foreach (VECS[k]) begin
            @(negedge clk);
            ce_n = VECS[k].ce;
            rnw  = VECS[k].dir;
            ds_n = 1'b0;
            #1;
            check(rd_n, VECS[k].erd, "R1 rd_n at strobe");
            check(wr_n, VECS[k].ewr, "R2 wr_n at strobe");
            check(ack_n, 1'b1, "R5 ack before edges");
            step();
            check(ack_n, 1'b1, "R5 ack after first edge");
            for (int h = 0; h < int'(VECS[k].hold); h++) begin
                step();
                check(ack_n, !VECS[k].eack, "R6 R8 ack during hold");
                check(rd_n, VECS[k].erd, "R1 R3 rd_n held");
            end
            @(negedge clk);
            ds_n = 1'b1;
            #1;
            check(ack_n, 1'b1, "R7 ack released at once");
            check(rd_n, 1'b1, "R3 rd_n idle");
            check(wr_n, 1'b1, "R3 wr_n idle");
            @(negedge clk);
            ce_n = 1'b1;
            step();
        end

        // R10: strobe across a single edge
        @(negedge clk);
        ce_n = 1'b0; rnw = 1'b1; ds_n = 1'b0;
        step();
        check(ack_n, 1'b1, "R10 one edge no ack");
        ds_n = 1'b1;
        #1;
        check(ack_n, 1'b1, "R10 after release");
        step();
        // R7: next cycle waits full latency again
        ds_n = 1'b0;
        step();
        check(ack_n, 1'b1, "R7 restart edge one");
        step();
        check(ack_n, 1'b0, "R7 restart edge two");
        ds_n = 1'b1;
        step();

        // R8: chip enable withdrawn mid-cycle
        ce_n = 1'b0; rnw = 1'b0; ds_n = 1'b0;
        step();
        step();
        check(ack_n, 1'b0, "R8 ack before ce drop");
        ce_n = 1'b1;
        #1;
        check(ack_n, 1'b1, "R8 ack at ce drop");
        check(wr_n, 1'b1, "R8 wr_n at ce drop");
        step();
        check(ack_n, 1'b1, "R8 ack after ce drop");
        ds_n = 1'b1;
        step();

        // R9: reset during an active strobe
        ce_n = 1'b0; rnw = 1'b1; ds_n = 1'b0;
        step();
        step();
        check(ack_n, 1'b0, "R9 ack before reset");
        rst = 1'b1;
        step();
        check(ack_n, 1'b1, "R9 ack after reset edge");
        step();
        check(ack_n, 1'b1, "R9 ack during reset");
        rst = 1'b0;
        step();
        check(ack_n, 1'b1, "R9 release edge one");
        step();
        check(ack_n, 1'b0, "R9 release edge two");
        check(rd_n, 1'b0, "R1 rd_n through reset");
        ds_n = 1'b1;
        #1;
        check(ack_n, 1'b1, "R7 final release");
        ce_n = 1'b1;
        step();

        finish_run();
    end

endmodule